// File: doc/BRIEF.md
# Shared-Ramp Single-Slope Conversion Controller

This block digitises the voltages held on a row of sampling cells, all at once, by the single-slope method. After a start request it clears every cell register, arms every cell, and then raises one digital ramp code by one step per clock. An external DAC turns that code into the ramp voltage seen by every comparator. The same code also serves as the shared count. Each cell has one comparator bit. On the first clock where an armed cell reads its comparator as 1, the cell stores the current count. Once the count reaches full scale, any cell that never tripped is loaded with the full-scale code and flagged as overrange.

When the ramp is finished the block raises done and sends the stored codes out on a valid/ready stream. Codes leave in cell-index order, one per accepted handshake. Start requests that arrive while a conversion or a readout is still running are ignored.

The controller has three states. **IDLE** moves to **RAMP** when start is seen (transition *accept*). **RAMP** moves to **SEND** on the clock that processes the full-scale count (transition *full*). **SEND** moves back to **IDLE** on the clock that accepts the last cell's code (transition *drained*). No other transitions exist.

Top module: `wilk_conv_ctrl`

## Requirements
- R1: After reset the block is in IDLE, and busy_o, done_o and out_valid_o are 0 and dac_code_o is 0.
- R2: A start_i sampled high in IDLE enters RAMP. On the next cycle busy_o is 1 and dac_code_o is 0. After that, dac_code_o rises by exactly 1 per clock while in RAMP. Outside RAMP, dac_code_o is 0.
- R3: A cell latches the value on dac_code_o from the first RAMP clock on which its comparator bit is 1. A bit that is 1 when dac_code_o is L gives code L.
- R4: A cell latches only once per conversion. Comparator changes after its first latch, including a return to 0, do not alter its code.
- R5: A cell whose comparator stays 0 through count 4095 gets code 4095 with its overrange bit set to 1. A cell that first reads 1 at count 4095 gets code 4095 with overrange 0.
- R6: done_o rises exactly 4096 clocks after the clock that accepted start. It stays 1 until the last code is accepted.
- R7: In SEND, out_valid_o is 1 and the block presents cells in index order 0 up to N_CELLS-1, on out_idx_o, out_code_o and out_ovr_o. A cell's code advances only on a clock where out_valid_o and out_ready_i are both 1. While out_ready_i is 0, the presented index, code and overrange bit stay fixed.
- R8: start_i is ignored in RAMP and in SEND. In RAMP the ramp keeps counting. In SEND the block stays in SEND and busy_o stays 0.
- R9: The clock that accepts cell N_CELLS-1 returns the block to IDLE. On the next cycle out_valid_o and done_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled in IDLE only |
| cmp_i | input | N_CELLS | One comparator result per cell, 1 = ramp has passed the stored level |
| dac_code_o | output | CNT_W | Ramp code to the DAC, equal to the shared count |
| busy_o | output | 1 | High while the ramp runs |
| done_o | output | 1 | High while stored codes are being streamed |
| out_valid_o | output | 1 | Stream valid |
| out_ready_i | input | 1 | Stream ready |
| out_code_o | output | CNT_W | Code of the presented cell |
| out_ovr_o | output | 1 | Overrange bit of the presented cell |
| out_idx_o | output | IDX_W | Index of the presented cell |

## Verification
- **Ramp code:** one cycle after the start edge, busy_o is 1 and dac_code_o is 0. From then on the bench expects dac_code_o to equal the number of clocks since that edge. It samples this on the falling edge, so each check sees the state left by exactly one rising edge.
- **Done timing:** the bench counts clocks from the accepting edge and requires done_o to appear first at exactly 4096.
- **Stream contents:** a scoreboard is filled from the comparator levels the bench programmed. A monitor compares each presented code on the falling edge before the rising edge that accepts it. This also proves that data stays stable while ready is held low.
- **Rejected starts and return to IDLE:** a start pulsed in RAMP or in SEND is checked one cycle later. The drop of done_o and valid is checked one cycle after the last accepting edge.

// File: rtl/wilk_pkg.sv
package wilk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RAMP = 2'd1,
        ST_SEND = 2'd2
    } conv_state_t;
endpackage

// File: rtl/wilk_ramp_ctr.sv
module wilk_ramp_ctr #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             at_full
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (run)    cnt <= cnt + 1'b1;
    end

    assign at_full = run && (cnt == FULL);

    // R2: the ramp moves by one step on every clock of a run
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/wilk_cell.sv
module wilk_cell #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             run,
    input  logic             full,
    input  logic             cmp,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] code,
    output logic             ovr
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            code  <= '0;
            ovr   <= 1'b0;
        end else if (arm) begin
            armed <= 1'b1;
            code  <= '0;
            ovr   <= 1'b0;
        end else if (run && armed) begin
            if (cmp) begin
                code  <= cnt;
                armed <= 1'b0;
            end else if (full) begin
                code  <= FULL;
                ovr   <= 1'b1;
                armed <= 1'b0;
            end
        end
    end

    // R4: once a cell has latched, its code holds until the next arm
    p_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !arm) |=> $stable(code));
    // R5: an overrange flag always comes with the full-scale code
    p_ovr_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> (code == FULL));
endmodule

// File: rtl/wilk_stream.sv
module wilk_stream #(
    parameter int N_CELLS = 8,
    parameter int CNT_W   = 12,
    parameter int IDX_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [N_CELLS*CNT_W-1:0] codes,
    input  logic [N_CELLS-1:0]       ovrs,
    input  logic                     ready,
    output logic                     valid,
    output logic [CNT_W-1:0]         code,
    output logic                     ovr,
    output logic [IDX_W-1:0]         idx,
    output logic                     last_acc
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CELLS - 1);

    logic [CNT_W-1:0] code_arr [N_CELLS];

    for (genvar g = 0; g < N_CELLS; g++) begin : g_unpack
        assign code_arr[g] = codes[g*CNT_W +: CNT_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              idx <= '0;
        else if (!en || last_acc) idx <= '0;
        else if (ready)          idx <= idx + 1'b1;
    end

    assign valid    = en;
    assign code     = code_arr[idx];
    assign ovr      = ovrs[idx];
    assign last_acc = en && ready && (idx == LAST);

    // R7: a stalled item stays put until it is accepted
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(idx) && $stable(code) && $stable(ovr)));
endmodule

// File: rtl/wilk_conv_ctrl.sv
module wilk_conv_ctrl
    import wilk_pkg::*;
#(
    parameter int N_CELLS = 8,
    parameter int CNT_W   = 12,
    parameter int IDX_W   = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [N_CELLS-1:0] cmp_i,
    output logic [CNT_W-1:0]   dac_code_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               out_valid_o,
    input  logic               out_ready_i,
    output logic [CNT_W-1:0]   out_code_o,
    output logic               out_ovr_o,
    output logic [IDX_W-1:0]   out_idx_o
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    conv_state_t state_q, state_d;

    logic                     start_ok;
    logic                     run;
    logic                     at_full;
    logic                     last_acc;
    logic [CNT_W-1:0]         cnt;
    logic [N_CELLS*CNT_W-1:0] codes;
    logic [N_CELLS-1:0]       ovrs;

    assign start_ok = (state_q == ST_IDLE) && start_i;
    assign run      = (state_q == ST_RAMP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)  state_d = ST_RAMP;
            ST_RAMP: if (at_full)  state_d = ST_SEND;
            ST_SEND: if (last_acc) state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o     = 1'b0;
        done_o     = 1'b0;
        dac_code_o = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RAMP: begin
                busy_o     = 1'b1;
                dac_code_o = cnt;
            end
            ST_SEND: done_o = 1'b1;
            default: ;
        endcase
    end

    wilk_ramp_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_ok),
        .run     (run),
        .cnt     (cnt),
        .at_full (at_full)
    );

    for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
        wilk_cell #(.CNT_W(CNT_W)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .arm   (start_ok),
            .run   (run),
            .full  (at_full),
            .cmp   (cmp_i[c]),
            .cnt   (cnt),
            .code  (codes[c*CNT_W +: CNT_W]),
            .ovr   (ovrs[c])
        );
    end

    wilk_stream #(.N_CELLS(N_CELLS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_stream (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (state_q == ST_SEND),
        .codes    (codes),
        .ovrs     (ovrs),
        .ready    (out_ready_i),
        .valid    (out_valid_o),
        .code     (out_code_o),
        .ovr      (out_ovr_o),
        .idx      (out_idx_o),
        .last_acc (last_acc)
    );

    // R8: no request can pull the block from readout back into a ramp
    p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND) |=> (state_q != ST_RAMP));
    // R6: done appears only right after the full-scale step
    p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(dac_code_o) == FULL));
    // R9: leaving readout always goes to idle with the stream quiet
    p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> (!out_valid_o && !busy_o));
endmodule

// File: tb/sim_wilk_conv_ctrl.sv
`timescale 1ns/1ps
module sim_wilk_conv_ctrl;
    localparam int N     = 8;
    localparam int CW    = 12;
    localparam int IW    = 3;
    localparam int FULLV = 4095;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [N-1:0]  cmp_i;
    logic [CW-1:0] dac_code_o;
    logic          busy_o, done_o, out_valid_o, out_ovr_o;
    logic          out_ready_i = 1'b0;
    logic [CW-1:0] out_code_o;
    logic [IW-1:0] out_idx_o;

    always #2.5 clk = ~clk;

    wilk_conv_ctrl #(.N_CELLS(N), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
        .dac_code_o(dac_code_o), .busy_o(busy_o), .done_o(done_o),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .out_code_o(out_code_o), .out_ovr_o(out_ovr_o), .out_idx_o(out_idx_o)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int lvl [N];
    bit tog [N];
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [IW+CW:0] sb [$];

    always @(posedge clk) cyc <= cyc + 1;

    // behavioural comparators; a toggling cell drops back to 0 three steps after tripping
    always_comb begin
        for (int i = 0; i < N; i++)
            cmp_i[i] = (int'(dac_code_o) >= lvl[i]) &&
                       (!tog[i] || int'(dac_code_o) < lvl[i] + 3);
    end

    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready_i <= (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? lfsr[3] : 1'b0;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // monitor: compares each item in the cycle before the edge that accepts it
    always @(negedge clk) begin
        if (rst_n && out_valid_o && out_ready_i) begin
            if (sb.size() == 0) begin
                check("R7 unexpected item", 1, 0);
            end else begin
                logic [IW+CW:0] e;
                e = sb.pop_front();
                check("R7 index order", int'(out_idx_o), int'(e[IW+CW:CW+1]));
                check("R3/R4/R5 code", int'(out_code_o), int'(e[CW:1]));
                check("R5 overrange", int'(out_ovr_o), int'(e[0]));
            end
        end
    end

    // driver: programs levels, pushes expectations, runs one ramp
    task automatic run_conv(input bit reject_in_send);
        int s;
        for (int i = 0; i < N; i++) begin
            logic [CW-1:0] c;
            logic o;
            c = (lvl[i] > FULLV) ? CW'(FULLV) : CW'(lvl[i]);
            o = (lvl[i] > FULLV);
            sb.push_back({IW'(i), c, o});
        end
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        s = cyc;
        check("R2 busy after start", int'(busy_o), 1);
        check("R2 ramp starts at 0", int'(dac_code_o), 0);
        repeat (100) @(negedge clk);
        check("R2 ramp step count", int'(dac_code_o), 100);
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check("R8 start ignored in RAMP", int'(dac_code_o), 101);
        while (!done_o) @(negedge clk);
        check("R6 done latency", cyc - s, 4096);
        check("R2 code 0 outside RAMP", int'(dac_code_o), 0);
        if (reject_in_send) begin
            check("R7 valid held while stalled", int'(out_valid_o), 1);
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            @(negedge clk);
            check("R8 start ignored in SEND busy", int'(busy_o), 0);
            check("R8 start ignored in SEND done", int'(done_o), 1);
            check("R7 index stable while stalled", int'(out_idx_o), 0);
            rdy_mode = 2;
        end
        while (done_o) @(negedge clk);
        check("R9 valid drops", int'(out_valid_o), 0);
        check("R9 back in IDLE", int'(busy_o), 0);
        check("R7 all items sent", sb.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin lvl[i] = 5000; tog[i] = 1'b0; end
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy_o), 0);
        check("R1 done", int'(done_o), 0);
        check("R1 valid", int'(out_valid_o), 0);
        check("R1 dac", int'(dac_code_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", int'(busy_o), 0);

        // conversion A: edges, overrange, toggling cell, stalled stream
        lvl[0] = 0;    lvl[1] = 17;   lvl[2] = 4095; lvl[3] = 9999;
        lvl[4] = 1234; lvl[5] = 200;  lvl[6] = 3000; lvl[7] = 4094;
        tog[5] = 1'b1;
        rdy_mode = 0;
        run_conv(1'b1);

        // conversion B: ready always high, descending levels
        for (int i = 0; i < N; i++) begin lvl[i] = 4000 - 500 * i; tog[i] = 1'b0; end
        tog[2] = 1'b1;
        rdy_mode = 1;
        run_conv(1'b0);

        // conversion C: all overrange except one, irregular ready
        for (int i = 0; i < N; i++) lvl[i] = 4096;
        lvl[6] = 1;
        rdy_mode = 2;
        run_conv(1'b0);

        finish_run();
    end

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule